// File: doc/BRIEF.md
# Local interrupt timer with deadline mode

A per-core timer that raises a one-cycle interrupt request carrying a programmed vector. The timer runs in one of three modes selected by a two-bit field of its control entry. In one-shot and periodic mode, a down-counter loaded from an initial-count register drops by one every 2^code bus cycles, where code is the divide setting. In deadline mode, a 64-bit absolute deadline is compared against a free-running time-stamp counter that arrives on an input port.

Software reaches the block through a small 32-bit register port (control entry, initial count, current count, divide setting) and a separate 64-bit deadline port. What each register does depends on the active mode. A configuration input states whether deadline mode exists. When it does not, only the low bit of the mode field can be written. A software-enable input forces the mask bit on whenever the control entry is written while the unit is disabled.

Top module: `local_timer`

## Requirements
- R1: Control entry (register select 0) keeps only the vector in bits 7:0, the mask in bit 16 and the mode in bits 18:17; all other written bits read back as 0, and bit 18 is kept only while `deadlineSupported` is 1. After reset the entry reads 0x0001_0000 and every other register reads 0. Mode codes are 0 one-shot, 1 periodic, 2 deadline, 3 reserved (no timer runs).
- R2: A control-entry write made while `swEnable` is 0 stores the mask bit as 1, whatever the written value.
- R3: A control-entry write that changes the mode field stops the countdown (current count reads 0) and disarms any pending deadline. A write that keeps the mode changes neither.
- R4: In one-shot or periodic mode, a write to the initial count (select 1) reloads the current count and restarts it; the divide setting (select 3, bits 2:0) gives a ratio of 2^code; the request rises initial×ratio clock edges after the loading edge.
- R5: An initial count of 0 leaves the countdown stopped, with no request and a current count (select 2) of 0.
- R6: In one-shot mode exactly one request is raised per load, after which the current count stays 0.
- R7: In periodic mode the current count reloads from the initial count on expiry and a request is raised every initial×ratio edges.
- R8: While the mask bit is 1, requests are suppressed but counting and reloading continue.
- R9: In deadline or reserved mode, initial-count writes are ignored (the stored initial count is unchanged and no countdown starts), and the current count reads 0.
- R10: Deadline writes are accepted only in deadline mode; in other modes they are dropped. The deadline reads 0 in one-shot and periodic mode and reads the stored value otherwise.
- R11: In deadline mode a nonzero deadline raises one request on the clock edge after the first cycle in which the time-stamp counter is at or above it, then disarms. A deadline already passed fires at once, and a deadline of 0 never fires.
- R12: A deadline write replaces and cancels any pending deadline.
- R13: `irqVector` carries the control-entry vector held in the cycle in which the expiry was detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| deadlineSupported | input | 1 | 1 makes the second mode bit writable |
| swEnable | input | 1 | Software enable of the timer unit |
| tsc | input | 64 | Free-running time-stamp counter |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 control, 1 initial, 2 current, 3 divide |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for `regAddr` (combinational) |
| dlWr | input | 1 | Deadline write strobe |
| dlWrData | input | 64 | Deadline write data |
| dlRdData | output | 64 | Deadline read data |
| irqValid | output | 1 | One-cycle interrupt request |
| irqVector | output | 8 | Vector carried with the request |

## Verification
The hardest case to reach is a deadline that is replaced while it is still pending, followed by a mode switch away from deadline and back. Only the counter compare shows whether the first value was really cancelled and whether the stored value survived the round trip. The stimulus writes a far deadline, overwrites it with a near one within two cycles, and counts exactly one request. It then arms another deadline, leaves deadline mode before it expires, waits past the expiry, tries a dropped write, and returns to read back the earlier value. A behavioural model tracks elapsed cycles and a pending flag and is compared against the outputs on every clock.

// File: rtl/lt_pkg.sv
package lt_pkg;

  typedef enum logic [1:0] {
    MODE_ONESHOT  = 2'd0,
    MODE_PERIODIC = 2'd1,
    MODE_DEADLINE = 2'd2,
    MODE_RSVD     = 2'd3
  } tmr_mode_e;

  localparam int LVT_MODE_LSB = 17;
  localparam int LVT_MASK_BIT = 16;
  localparam int VEC_W        = 8;

  localparam logic [1:0] SEL_LVT  = 2'd0;
  localparam logic [1:0] SEL_INIT = 2'd1;
  localparam logic [1:0] SEL_CUR  = 2'd2;
  localparam logic [1:0] SEL_DIV  = 2'd3;

  typedef struct packed {
    logic cntLoad;
    logic cntStop;
    logic dlLoad;
    logic dlDrop;
  } tmr_strobe_t;

endpackage

// File: rtl/lt_ctrl.sv
module lt_ctrl
  import lt_pkg::*;
#(
  parameter int COUNT_W = 32,
  parameter int TSC_W   = 64,
  parameter int DIV_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               deadlineSupported,
  input  logic               swEnable,
  input  logic               regWr,
  input  logic [1:0]         regAddr,
  input  logic [31:0]        regWdata,
  input  logic               dlWr,
  input  logic [COUNT_W-1:0] curCount,
  input  logic [TSC_W-1:0]   deadlineVal,
  output logic [31:0]        regRdata,
  output logic [TSC_W-1:0]   dlRdData,
  output tmr_strobe_t        strb,
  output tmr_mode_e          effMode,
  output logic [31:0]        lvtReg,
  output logic [COUNT_W-1:0] initReg,
  output logic [DIV_W-1:0]   divCode
);

  localparam logic [31:0] FIXED_KEEP = (32'h1 << LVT_MASK_BIT) | ((32'h1 << VEC_W) - 32'h1);
  localparam logic [31:0] MASK_FORCE = 32'h1 << LVT_MASK_BIT;

  logic [31:0] modeKeep;
  logic [1:0]  oldField;
  logic [1:0]  newField;
  logic        lvtHit;
  logic        initHit;
  logic        divHit;
  logic        modeChange;
  logic        countMode;

  always_comb begin
    modeKeep   = deadlineSupported ? (32'h3 << LVT_MODE_LSB) : (32'h1 << LVT_MODE_LSB);
    oldField   = lvtReg[LVT_MODE_LSB +: 2] & modeKeep[LVT_MODE_LSB +: 2];
    newField   = regWdata[LVT_MODE_LSB +: 2] & modeKeep[LVT_MODE_LSB +: 2];
    effMode    = tmr_mode_e'(oldField);
    lvtHit     = regWr && (regAddr == SEL_LVT);
    initHit    = regWr && (regAddr == SEL_INIT);
    divHit     = regWr && (regAddr == SEL_DIV);
    modeChange = lvtHit && (newField != oldField);
    countMode  = (effMode == MODE_ONESHOT) || (effMode == MODE_PERIODIC);

    strb.cntStop = modeChange;
    strb.dlDrop  = modeChange;
    strb.cntLoad = initHit && countMode;
    strb.dlLoad  = dlWr && (effMode == MODE_DEADLINE) && !modeChange;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lvtReg  <= MASK_FORCE;
      initReg <= '0;
      divCode <= '0;
    end else begin
      if (lvtHit)
        lvtReg <= (regWdata | (swEnable ? 32'h0 : MASK_FORCE)) & (FIXED_KEEP | modeKeep);
      if (strb.cntLoad)
        initReg <= regWdata[COUNT_W-1:0];
      if (divHit)
        divCode <= regWdata[DIV_W-1:0];
    end
  end

  always_comb begin
    case (regAddr)
      SEL_LVT:  regRdata = lvtReg;
      SEL_INIT: regRdata = 32'(initReg);
      SEL_CUR:  regRdata = countMode ? 32'(curCount) : 32'h0;
      default:  regRdata = 32'(divCode);
    endcase
    dlRdData = countMode ? '0 : deadlineVal;
  end

endmodule

// File: rtl/lt_datapath.sv
module lt_datapath
  import lt_pkg::*;
#(
  parameter int COUNT_W = 32,
  parameter int TSC_W   = 64,
  parameter int DIV_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  tmr_strobe_t        strb,
  input  logic               periodic,
  input  logic               masked,
  input  logic [VEC_W-1:0]   vector,
  input  logic [COUNT_W-1:0] loadVal,
  input  logic [COUNT_W-1:0] initVal,
  input  logic [DIV_W-1:0]   divCode,
  input  logic [TSC_W-1:0]   tsc,
  input  logic [TSC_W-1:0]   dlWrData,
  output logic [COUNT_W-1:0] curCount,
  output logic [TSC_W-1:0]   deadlineVal,
  output logic               running,
  output logic               dlArmed,
  output logic               irqValid,
  output logic [VEC_W-1:0]   irqVector
);

  localparam int PRE_W = (1 << DIV_W) - 1;

  logic [PRE_W-1:0] prescale;
  logic [PRE_W-1:0] tickAt;
  logic             tick;
  logic             cdFire;
  logic             dlFire;

  always_comb begin
    tickAt = ~({PRE_W{1'b1}} << divCode);
    tick   = running && (prescale >= tickAt) && !strb.cntLoad && !strb.cntStop;
    cdFire = tick && (curCount == COUNT_W'(1));
    dlFire = dlArmed && (tsc >= deadlineVal) && !strb.dlLoad && !strb.dlDrop;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curCount <= '0;
      prescale <= '0;
      running  <= 1'b0;
    end else if (strb.cntStop) begin
      curCount <= '0;
      prescale <= '0;
      running  <= 1'b0;
    end else if (strb.cntLoad) begin
      curCount <= loadVal;
      prescale <= '0;
      running  <= (loadVal != '0);
    end else if (running) begin
      if (tick) begin
        prescale <= '0;
        if (cdFire) begin
          curCount <= periodic ? initVal : '0;
          running  <= periodic;
        end else begin
          curCount <= curCount - COUNT_W'(1);
        end
      end else begin
        prescale <= prescale + PRE_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      deadlineVal <= '0;
      dlArmed     <= 1'b0;
    end else if (strb.dlDrop) begin
      dlArmed <= 1'b0;
    end else if (strb.dlLoad) begin
      deadlineVal <= dlWrData;
      dlArmed     <= (dlWrData != '0);
    end else if (dlFire) begin
      dlArmed <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqValid  <= 1'b0;
      irqVector <= '0;
    end else begin
      irqValid  <= (cdFire || dlFire) && !masked;
      irqVector <= vector;
    end
  end

endmodule

// File: rtl/local_timer.sv
module local_timer
  import lt_pkg::*;
#(
  parameter int COUNT_W = 32,
  parameter int TSC_W   = 64,
  parameter int DIV_W   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             deadlineSupported,
  input  logic             swEnable,
  input  logic [TSC_W-1:0] tsc,
  input  logic             regWr,
  input  logic [1:0]       regAddr,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  input  logic             dlWr,
  input  logic [TSC_W-1:0] dlWrData,
  output logic [TSC_W-1:0] dlRdData,
  output logic             irqValid,
  output logic [VEC_W-1:0] irqVector
);

  tmr_strobe_t        strb;
  tmr_mode_e          effMode;
  logic [31:0]        lvtReg;
  logic [COUNT_W-1:0] initReg;
  logic [DIV_W-1:0]   divCode;
  logic [COUNT_W-1:0] curCount;
  logic [TSC_W-1:0]   deadlineVal;
  logic               running;
  logic               dlArmed;

  lt_ctrl #(.COUNT_W(COUNT_W), .TSC_W(TSC_W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .deadlineSupported(deadlineSupported), .swEnable(swEnable),
    .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata), .dlWr(dlWr),
    .curCount(curCount), .deadlineVal(deadlineVal),
    .regRdata(regRdata), .dlRdData(dlRdData),
    .strb(strb), .effMode(effMode), .lvtReg(lvtReg),
    .initReg(initReg), .divCode(divCode)
  );

  lt_datapath #(.COUNT_W(COUNT_W), .TSC_W(TSC_W), .DIV_W(DIV_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .periodic(effMode == MODE_PERIODIC),
    .masked(lvtReg[LVT_MASK_BIT]),
    .vector(lvtReg[VEC_W-1:0]),
    .loadVal(regWdata[COUNT_W-1:0]),
    .initVal(initReg), .divCode(divCode),
    .tsc(tsc), .dlWrData(dlWrData),
    .curCount(curCount), .deadlineVal(deadlineVal),
    .running(running), .dlArmed(dlArmed),
    .irqValid(irqValid), .irqVector(irqVector)
  );

endmodule

// File: rtl/lt_chk.sv
module lt_chk #(
  parameter int TSC_W = 64
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWr,
  input logic [1:0]       regAddr,
  input logic [31:0]      regWdata,
  input logic             swEnable,
  input logic             dlWr,
  input logic             irqValid,
  input logic [31:0]      regRdata,
  input logic [TSC_W-1:0] dlRdData,
  input logic [31:0]      lvtReg,
  input logic [1:0]       effMode,
  input logic             running,
  input logic             dlArmed,
  input logic [TSC_W-1:0] deadlineVal
);

  // R2
  sw_mask_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 2'd0 && !swEnable) |=> lvtReg[16]);

  // R3
  mode_change_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 2'd0 && (regWdata[17] != lvtReg[17])) |=> (!running && !dlArmed));

  // R8
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> !$past(lvtReg[16]));

  // R9
  dl_cur_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (effMode == 2'd2 && regAddr == 2'd2) |-> (regRdata == 32'h0));

  // R9
  dl_no_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (effMode == 2'd2) |-> !running);

  // R10
  dl_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (effMode == 2'd0 || effMode == 2'd1) |-> (dlRdData == '0));

  // R10
  dl_drop_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dlWr && effMode != 2'd2) |=> $stable(deadlineVal));

endmodule

bind local_timer lt_chk #(.TSC_W(TSC_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
  .swEnable(swEnable), .dlWr(dlWr), .irqValid(irqValid), .regRdata(regRdata),
  .dlRdData(dlRdData), .lvtReg(lvtReg), .effMode(effMode), .running(running),
  .dlArmed(dlArmed), .deadlineVal(deadlineVal)
);

// File: tb/test_local_timer.sv
module test_local_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        deadlineSupported = 1'b1;
  logic        swEnable = 1'b1;
  logic [63:0] tsc = 64'd1000;
  logic        regWr = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWdata = 32'h0;
  logic        dlWr = 1'b0;
  logic [63:0] dlWrData = 64'h0;
  logic [31:0] regRdata;
  logic [63:0] dlRdData;
  logic        irqValid;
  logic [7:0]  irqVector;

  int    checks = 0;
  int    errors = 0;
  int    irqSeen = 0;
  string curReq = "R1";

  // reference model state
  logic [31:0]     mLvt;
  longint unsigned mInit, mDiv, mCur, mElapsed;
  logic [63:0]     mDl;
  bit              mRun, mArm, mIrq;
  logic [7:0]      mVec;

  local_timer i_local_timer (
    .clk(clk), .rstN(rstN), .deadlineSupported(deadlineSupported), .swEnable(swEnable),
    .tsc(tsc), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .dlWr(dlWr), .dlWrData(dlWrData), .dlRdData(dlRdData),
    .irqValid(irqValid), .irqVector(irqVector)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) tsc <= tsc + 64'd1;

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", curReq, what, act, exp);
    end
  endtask

  function automatic int modeNow();
    int keep;
    keep = deadlineSupported ? 3 : 1;
    return int'((mLvt >> 17) & 32'(keep));
  endfunction

  function automatic logic [31:0] expRead(input logic [1:0] a);
    case (a)
      2'd0: return mLvt;
      2'd1: return 32'(mInit);
      2'd2: return (modeNow() < 2) ? 32'(mCur) : 32'h0;
      default: return 32'(mDiv);
    endcase
  endfunction

  task automatic modelStep();
    int keep, oldMode, newMode;
    bit fire, masked, chg, lvtW;
    longint unsigned ratio;
    if (!rstN) begin
      mLvt = 32'h0001_0000; mInit = 0; mDiv = 0; mCur = 0; mElapsed = 0;
      mDl = 0; mRun = 0; mArm = 0; mIrq = 0; mVec = 0;
    end else begin
      keep    = deadlineSupported ? 3 : 1;
      oldMode = modeNow();
      masked  = mLvt[16];
      fire    = 0;
      lvtW    = regWr && regAddr == 2'd0;
      newMode = int'((regWdata >> 17) & 32'(keep));
      chg     = lvtW && (newMode != oldMode);
      if (chg) begin
        mRun = 0; mCur = 0; mArm = 0;
      end else begin
        if (regWr && regAddr == 2'd1 && oldMode < 2) begin
          mInit = regWdata; mElapsed = 0; mRun = (regWdata != 0); mCur = regWdata;
        end else if (mRun) begin
          ratio = 64'd1 << mDiv;
          mElapsed++;
          if (mElapsed % (mInit * ratio) == 0) fire = 1;
          if (oldMode == 0 && fire) begin mRun = 0; mCur = 0; end
          else mCur = mInit - ((mElapsed / ratio) % mInit);
        end
        if (dlWr && oldMode == 2) begin
          mDl = dlWrData; mArm = (dlWrData != 0);
        end else if (mArm && tsc >= mDl) begin
          fire = 1; mArm = 0;
        end
      end
      mIrq = fire && !masked;
      mVec = mLvt[7:0];
      if (lvtW)
        mLvt = (regWdata | (swEnable ? 32'h0 : 32'h0001_0000)) & (32'h0001_00FF | (32'(keep) << 17));
      if (regWr && regAddr == 2'd3) mDiv = regWdata & 32'h7;
    end
  endtask

  // model steps on each edge, outputs compared a quarter period later
  always @(posedge clk) begin
    modelStep();
    #(CLK_PERIOD/4);
    if (irqValid === 1'b1) irqSeen++;
    chk("irqValid", 64'(irqValid), 64'(mIrq));
    if (mIrq) chk("irqVector R13", 64'(irqVector), 64'(mVec));
    chk("regRdata", 64'(regRdata), 64'(expRead(regAddr)));
    chk("dlRdData", dlRdData, (modeNow() < 2) ? 64'h0 : mDl);
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic wrDl(input logic [63:0] d);
    dlWr = 1'b1; dlWrData = d;
    @(negedge clk);
    dlWr = 1'b0;
  endtask

  task automatic idle(input int n, input logic [1:0] a);
    regAddr = a;
    repeat (n) @(negedge clk);
  endtask

  task automatic peek(input logic [1:0] a, input logic [31:0] exp, input string what);
    regAddr = a;
    #1;
    chk(what, 64'(regRdata), 64'(exp));
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected finished");
    finishRun();
  end

  initial begin
    logic [63:0] keptDl;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    curReq = "R1";
    peek(2'd0, 32'h0001_0000, "control reset value R1");
    wr(2'd0, 32'hFFFF_FFFF);
    peek(2'd0, 32'h0007_00FF, "control kept bits R1");

    curReq = "R9";
    wr(2'd1, 32'd9);
    peek(2'd1, 32'h0, "initial ignored in reserved mode R9");

    curReq = "R4";
    wr(2'd0, 32'h0000_0031);
    wr(2'd3, 32'd2);
    irqSeen = 0;
    wr(2'd1, 32'd5);
    idle(25, 2'd2);
    curReq = "R6";
    chk("one-shot request count R6", 64'(irqSeen), 64'd1);
    peek(2'd2, 32'h0, "one-shot current after expiry R6");

    curReq = "R7";
    wr(2'd3, 32'd0);
    wr(2'd0, 32'h0002_0042);
    irqSeen = 0;
    wr(2'd1, 32'd3);
    idle(12, 2'd2);
    chk("periodic request count R7", 64'(irqSeen), 64'd4);

    curReq = "R8";
    wr(2'd0, 32'h0003_0042);
    irqSeen = 0;
    idle(9, 2'd2);
    chk("masked request count R8", 64'(irqSeen), 64'd0);
    wr(2'd0, 32'h0002_0042);
    idle(7, 2'd2);

    curReq = "R5";
    irqSeen = 0;
    wr(2'd1, 32'd0);
    idle(6, 2'd2);
    chk("zero initial requests R5", 64'(irqSeen), 64'd0);
    peek(2'd2, 32'h0, "zero initial current R5");

    curReq = "R3";
    wr(2'd1, 32'd10);
    idle(3, 2'd2);
    wr(2'd0, 32'h0000_0042);
    irqSeen = 0;
    idle(15, 2'd2);
    chk("requests after mode change R3", 64'(irqSeen), 64'd0);
    peek(2'd2, 32'h0, "current after mode change R3");

    curReq = "R9";
    wr(2'd0, 32'h0004_0055);
    wr(2'd1, 32'd7);
    peek(2'd1, 32'd10, "initial kept in deadline mode R9");
    peek(2'd2, 32'h0, "current reads zero in deadline mode R9");

    curReq = "R11";
    irqSeen = 0;
    wrDl(tsc + 64'd8);
    idle(20, 2'd1);
    chk("future deadline fires once R11", 64'(irqSeen), 64'd1);
    irqSeen = 0;
    wrDl(tsc - 64'd3);
    idle(3, 2'd1);
    chk("past deadline fires at once R11", 64'(irqSeen), 64'd1);
    irqSeen = 0;
    wrDl(64'd0);
    idle(5, 2'd1);
    chk("zero deadline silent R11", 64'(irqSeen), 64'd0);

    curReq = "R12";
    irqSeen = 0;
    wrDl(tsc + 64'd30);
    idle(2, 2'd1);
    wrDl(tsc + 64'd4);
    idle(40, 2'd1);
    chk("replaced deadline fires once R12", 64'(irqSeen), 64'd1);

    curReq = "R10";
    keptDl = tsc + 64'd100;
    wrDl(keptDl);
    wr(2'd0, 32'h0000_0055);
    irqSeen = 0;
    idle(110, 2'd1);
    chk("disarmed by mode change R10", 64'(irqSeen), 64'd0);
    #1;
    chk("deadline reads zero in one-shot R10", dlRdData, 64'h0);
    wrDl(64'd123);
    wr(2'd0, 32'h0004_0055);
    #1;
    chk("stored deadline survives R10", dlRdData, keptDl);

    curReq = "R2";
    swEnable = 1'b0;
    wr(2'd0, 32'h0000_0031);
    peek(2'd0, 32'h0001_0031, "mask forced while disabled R2");
    swEnable = 1'b1;

    curReq = "R1";
    deadlineSupported = 1'b0;
    wr(2'd0, 32'h0004_0012);
    peek(2'd0, 32'h0000_0012, "upper mode bit dropped R1");
    irqSeen = 0;
    wr(2'd1, 32'd2);
    idle(6, 2'd2);
    chk("one-shot without deadline support R1", 64'(irqSeen), 64'd1);

    idle(3, 2'd0);
    finishRun();
  end

endmodule